// File: doc/BRIEF.md
# Page-Aligned Flash Program and Erase Sequencer

This block turns one region-level request into the chain of single commands a serial flash device needs. A program request names a flash start address, a byte count and a source address in local memory. The block cuts the region into pieces so that no piece crosses a 256-byte page. Each piece is bracketed by its own write-enable and write-disable commands, and the block waits for the device to report idle before it moves on. An erase request walks the region in 4096-byte steps. Each step gets a write-enable, a sector erase and a busy wait.

Below the sequencer sits a command engine. It shifts the actual bytes on the serial bus. The sequencer hands it one command at a time over a start/done pair, with fields for the opcode, the 3-byte flash address, a byte mask, a data length and a local memory address. For status reads the engine returns the byte it read. The sequencer runs one operation at a time. It raises `busy` while working and ends every accepted request with a one-cycle `done`, which carries `err` when the request failed.

Top module: `flash_region_seq`

## Requirements
- R1: Each program piece is issued as: write enable (opcode 0x06), page program (opcode 0x02), one or more status reads, and finally write disable (opcode 0x04). The page program carries the piece's flash address, its length and the current source address on `cmd_mem`.
- R2: The first program piece has length min(request length, 256 - (start address mod 256)), so it never runs past the end of its page.
- R3: Every later program piece has length min(256, bytes left). After each piece, both the flash address and the source address move forward by that piece's length.
- R4: An erase issues, for each step, write enable (0x06) and then sector erase (opcode 0x20) with the current address, followed by status polling and no write disable. The address begins at the request address and grows by 4096 per step. There are ceil(length/4096) steps, so a zero-length erase ends with `done` and `err` low and issues no command.
- R5: Status polling uses opcode 0x05 with a data length of 1. The read byte's bit 0 is the busy flag and the other bits are ignored. A read with bit 0 set is followed by another status read. The next step begins only after a read with bit 0 clear.
- R6: A program request with length 0 issues no command and gives `done` with `err` high in the cycle after it is accepted.
- R7: Within one polling phase, up to `poll_limit` status reads with bit 0 set are tolerated. If one more such read arrives, the operation ends at once with `done` and `err` high, and no further command is issued. `poll_limit` is captured when the request is accepted.
- R8: `done` is a one-cycle pulse in the cycle after the final command's `cmd_done` (or after acceptance when no command is issued). `err` is low on success. `busy` is high from the cycle after acceptance through the `done` cycle, and it is low at reset.
- R9: A `req_valid` that arrives while `busy` is high is ignored. It adds no command and leaves the running operation unchanged.
- R10: `cmd_mask` bit 0 means the opcode byte is sent and bits 3:1 mean the three address bytes are sent. Commands with an address use mask 4'b1111, opcode-only commands use 4'b0001 with address 0, and commands without data carry length 0. `cmd_start` lasts one cycle, and the next `cmd_start` waits for `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_erase | input | 1 | 1 = erase region, 0 = program region |
| req_addr | input | 24 | Flash start address |
| req_len | input | LEN_W | Region length in bytes |
| req_src | input | SRC_W | Local memory source address (program) |
| poll_limit | input | POLL_W | Busy status reads tolerated per polling phase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Failure flag, valid with `done` |
| cmd_start | output | 1 | One-cycle command launch to the engine |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Flash address for the command |
| cmd_mask | output | 4 | Which command bytes are sent |
| cmd_len | output | 9 | Data bytes moved by the command |
| cmd_mem | output | SRC_W | Local memory address for data |
| cmd_done | input | 1 | Engine finished the current command |
| cmd_rdata | input | 8 | Status byte returned with `cmd_done` |

## Verification
The bench aims at the page-boundary arithmetic. It uses a start one byte before a boundary, a start whose length ends inside the page, and an aligned run whose tail is short. A design that clamps the wrong way would either spill a piece across a page or send a piece of length 0 or 256 where a short one is due. The bench also targets the polling limit from both sides: exactly `poll_limit` busy reads must pass, and one more must abort with `err`. An off-by-one counter would abort a healthy operation or let a stuck device hang the block. The bench also covers zero-length program versus zero-length erase, an erase length one byte past a sector multiple, and a stray request during a running operation. Each of these would show up as an extra, missing or reordered command in the per-cycle comparison.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int FADDR_W      = 24;
    localparam int PAGE_LG      = 8;
    localparam int PAGE_BYTES   = 1 << PAGE_LG;
    localparam int SECTOR_BYTES = 4096;
    localparam int XFER_W       = PAGE_LG + 1;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'h20;
    localparam logic [7:0] OP_STAT   = 8'h05;

    localparam logic [3:0] MASK_OPC  = 4'b0001;
    localparam logic [3:0] MASK_ADDR = 4'b1111;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WREN,
        PH_MAIN,
        PH_POLL,
        PH_WRDI,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic [7:0]         opcode;
        logic [FADDR_W-1:0] addr;
        logic [3:0]         mask;
        logic [XFER_W-1:0]  len;
    } flash_cmd_t;

    // Bytes left in the page that holds address a (1 .. PAGE_BYTES).
    function automatic logic [XFER_W-1:0] page_room(input logic [FADDR_W-1:0] a);
        return XFER_W'(PAGE_BYTES) - {1'b0, a[PAGE_LG-1:0]};
    endfunction

endpackage

// File: rtl/fseq_chunk_calc.sv
module fseq_chunk_calc import fseq_pkg::*; #(
    parameter int LEN_W = 20
) (
    input  logic               erase,
    input  logic [FADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]   remain,
    output logic [LEN_W-1:0]   step
);
    localparam logic [LEN_W-1:0] SECTOR_L = LEN_W'(SECTOR_BYTES);

    logic [LEN_W-1:0] cap;

    always_comb begin
        cap  = erase ? SECTOR_L : LEN_W'(page_room(addr));
        step = (remain < cap) ? remain : cap;
    end
endmodule

// File: rtl/fseq_poll_guard.sv
module fseq_poll_guard #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              busy_read,
    input  logic [POLL_W-1:0] limit,
    output logic              overrun
);
    logic [POLL_W-1:0] busy_cnt;

    assign overrun = busy_read && (busy_cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy_cnt <= '0;
        end else if (busy_read && !overrun) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= limit); // R7
endmodule

// File: rtl/fseq_cmd_encode.sv
module fseq_cmd_encode import fseq_pkg::*; (
    input  phase_t             phase,
    input  logic               erase,
    input  logic [FADDR_W-1:0] addr,
    input  logic [XFER_W-1:0]  xfer,
    output flash_cmd_t         cmd
);
    always_comb begin
        cmd.opcode = OP_WREN;
        cmd.addr   = '0;
        cmd.mask   = MASK_OPC;
        cmd.len    = '0;
        case (phase)
            PH_MAIN: begin
                cmd.opcode = erase ? OP_SERASE : OP_PROG;
                cmd.addr   = addr;
                cmd.mask   = MASK_ADDR;
                cmd.len    = erase ? '0 : xfer;
            end
            PH_POLL: begin
                cmd.opcode = OP_STAT;
                cmd.len    = XFER_W'(1);
            end
            PH_WRDI: cmd.opcode = OP_WRDI;
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_region_seq.sv
module flash_region_seq import fseq_pkg::*; #(
    parameter int LEN_W  = 20,
    parameter int SRC_W  = 24,
    parameter int POLL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_erase,
    input  logic [FADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [POLL_W-1:0]  poll_limit,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               cmd_start,
    output logic [7:0]         cmd_opcode,
    output logic [FADDR_W-1:0] cmd_addr,
    output logic [3:0]         cmd_mask,
    output logic [XFER_W-1:0]  cmd_len,
    output logic [SRC_W-1:0]   cmd_mem,
    input  logic               cmd_done,
    input  logic [7:0]         cmd_rdata
);
    localparam int SUM_W = XFER_W + 1;

    phase_t             phase;
    logic               waiting;
    logic               erase_q;
    logic               err_q;
    logic [FADDR_W-1:0] faddr;
    logic [SRC_W-1:0]   saddr;
    logic [LEN_W-1:0]   remain;
    logic [POLL_W-1:0]  limit_q;

    logic [LEN_W-1:0]   step_len;
    flash_cmd_t         cmd;
    logic               ack;
    logic               busy_read;
    logic               overrun;
    logic               last_step;
    logic               unused_status;

    fseq_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
        .erase  (erase_q),
        .addr   (faddr),
        .remain (remain),
        .step   (step_len)
    );

    fseq_cmd_encode u_enc (
        .phase (phase),
        .erase (erase_q),
        .addr  (faddr),
        .xfer  (XFER_W'(step_len)),
        .cmd   (cmd)
    );

    fseq_poll_guard #(.POLL_W(POLL_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .clear     (phase != PH_POLL),
        .busy_read (busy_read),
        .limit     (limit_q),
        .overrun   (overrun)
    );

    assign ack           = waiting && cmd_done;
    assign busy_read     = ack && (phase == PH_POLL) && cmd_rdata[0];
    assign last_step     = (remain == step_len);
    assign unused_status = ^cmd_rdata[7:1];

    assign cmd_start  = (phase inside {PH_WREN, PH_MAIN, PH_POLL, PH_WRDI}) && !waiting;
    assign cmd_opcode = cmd.opcode;
    assign cmd_addr   = cmd.addr;
    assign cmd_mask   = cmd.mask;
    assign cmd_len    = cmd.len;
    assign cmd_mem    = saddr;

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_FIN);
    assign err  = (phase == PH_FIN) && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            waiting <= 1'b0;
            erase_q <= 1'b0;
            err_q   <= 1'b0;
            faddr   <= '0;
            saddr   <= '0;
            remain  <= '0;
            limit_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        erase_q <= req_erase;
                        faddr   <= req_addr;
                        saddr   <= req_src;
                        remain  <= req_len;
                        limit_q <= poll_limit;
                        waiting <= 1'b0;
                        if (req_len == '0) begin
                            phase <= PH_FIN;
                            err_q <= !req_erase;
                        end else begin
                            phase <= PH_WREN;
                            err_q <= 1'b0;
                        end
                    end
                end
                PH_FIN: phase <= PH_IDLE;
                default: begin
                    if (cmd_start) begin
                        waiting <= 1'b1;
                    end else if (ack) begin
                        waiting <= 1'b0;
                        case (phase)
                            PH_WREN: phase <= PH_MAIN;
                            PH_MAIN: phase <= PH_POLL;
                            PH_POLL: begin
                                if (overrun) begin
                                    phase <= PH_FIN;
                                    err_q <= 1'b1;
                                end else if (!cmd_rdata[0]) begin
                                    if (erase_q) begin
                                        faddr  <= faddr + FADDR_W'(SECTOR_BYTES);
                                        remain <= remain - step_len;
                                        phase  <= last_step ? PH_FIN : PH_WREN;
                                    end else begin
                                        phase <= PH_WRDI;
                                    end
                                end
                            end
                            PH_WRDI: begin
                                faddr  <= faddr + FADDR_W'(step_len);
                                saddr  <= saddr + SRC_W'(step_len);
                                remain <= remain - step_len;
                                phase  <= last_step ? PH_FIN : PH_WREN;
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    AST_PAGE_FIT: assert property (@(posedge clk) disable iff (rst)
        cmd_start && cmd_opcode == OP_PROG |->
            cmd_len != '0 &&
            ({2'b00, cmd_addr[PAGE_LG-1:0]} + {1'b0, cmd_len}) <= SUM_W'(PAGE_BYTES)); // R2

    AST_ZERO_LEN_FAIL: assert property (@(posedge clk) disable iff (rst)
        !busy && req_valid && !req_erase && req_len == '0 |=> done && err && !cmd_start); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        busy && !cmd_start && !cmd_done && !done |=>
            $stable(cmd_opcode) && $stable(cmd_addr) && $stable(cmd_len) && !cmd_start || done); // R10

    AST_IGNORE_REQ: assert property (@(posedge clk) disable iff (rst)
        busy && req_valid && !cmd_done |=> $stable(cmd_mem) && $stable(cmd_addr)); // R9

    AST_BUSY_REPOLL: assert property (@(posedge clk) disable iff (rst)
        busy_read && !overrun |=> cmd_start && cmd_opcode == OP_STAT); // R5
endmodule

// File: tb/flash_region_seq_tb.sv
module flash_region_seq_tb;
    import fseq_pkg::*;

    localparam int LEN_W  = 20;
    localparam int SRC_W  = 24;
    localparam int POLL_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic               req_valid = 1'b0;
    logic               req_erase = 1'b0;
    logic [FADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [SRC_W-1:0]   req_src = '0;
    logic [POLL_W-1:0]  poll_limit = '0;
    logic               busy, done, err;
    logic               cmd_start;
    logic [7:0]         cmd_opcode;
    logic [FADDR_W-1:0] cmd_addr;
    logic [3:0]         cmd_mask;
    logic [XFER_W-1:0]  cmd_len;
    logic [SRC_W-1:0]   cmd_mem;
    logic               cmd_done = 1'b0;
    logic [7:0]         cmd_rdata = '0;

    flash_region_seq #(.LEN_W(LEN_W), .SRC_W(SRC_W), .POLL_W(POLL_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_len(req_len), .req_src(req_src),
        .poll_limit(poll_limit), .busy(busy), .done(done), .err(err),
        .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
        .cmd_mask(cmd_mask), .cmd_len(cmd_len), .cmd_mem(cmd_mem),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    typedef struct packed {
        logic [7:0]         op;
        logic [FADDR_W-1:0] addr;
        logic [3:0]         mask;
        logic [XFER_W-1:0]  len;
        logic [SRC_W-1:0]   mem;
        logic [7:0]         rdata;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int    total = 0;
    int    bad = 0;
    bit    active = 0;
    bit    fin_pending = 0;
    bit    exp_err = 0;
    string fin_tag = "R8";
    int    resp_cnt = -1;
    logic [7:0] resp_data = '0;
    bit    resp_last = 0;
    int    delay_seed = 0;
    bit    finished = 0;

    function automatic void check(bit ok, string tag, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endfunction

    function automatic void push(logic [7:0] op, int a, logic [3:0] m, int l, int s,
                                 logic [7:0] rd, string t);
        exp_t e;
        e.op    = op;
        e.addr  = a[FADDR_W-1:0];
        e.mask  = m;
        e.len   = l[XFER_W-1:0];
        e.mem   = s[SRC_W-1:0];
        e.rdata = rd;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endfunction

    // Returns 1 when the poll phase aborts on the limit.
    function automatic bit push_polls(int busy_n, int lim, int s);
        for (int k = 0; k < busy_n; k++) begin
            push(OP_STAT, 0, 4'b0001, 1, s, 8'h03, "R5");
            if (k == lim) begin
                exp_err = 1;
                fin_tag = "R7";
                return 1;
            end
        end
        push(OP_STAT, 0, 4'b0001, 1, s, 8'h02, "R5");
        return 0;
    endfunction

    function automatic void plan_program(int addr, int len, int src, int busy_n, int lim);
        int rem;
        int a;
        int s;
        bit first;
        rem = len; a = addr; s = src; first = 1;
        exp_err = 0;
        fin_tag = "R8";
        if (len == 0) begin
            exp_err = 1;
            fin_tag = "R6";
            return;
        end
        while (rem > 0) begin
            int room;
            int c;
            room = 256 - (a % 256);
            c = (rem < room) ? rem : room;
            push(OP_WREN, 0, 4'b0001, 0, s, 8'h00, "R1");
            push(OP_PROG, a, 4'b1111, c, s, 8'h00, first ? "R2" : "R3");
            if (push_polls(busy_n, lim, s)) return;
            push(OP_WRDI, 0, 4'b0001, 0, s, 8'h00, "R1");
            rem = rem - c; a = a + c; s = s + c; first = 0;
        end
    endfunction

    function automatic void plan_erase(int addr, int len, int busy_n, int lim);
        int rem;
        int a;
        rem = len; a = addr;
        exp_err = 0;
        fin_tag = "R4";
        while (rem > 0) begin
            int c;
            c = (rem < 4096) ? rem : 4096;
            push(OP_WREN, 0, 4'b0001, 0, 0, 8'h00, "R4");
            push(OP_SERASE, a, 4'b1111, 0, 0, 8'h00, "R4");
            if (push_polls(busy_n, lim, 0)) return;
            rem = rem - c; a = a + 4096;
        end
    endfunction

    task automatic start_op(bit erase, int addr, int len, int src, int lim);
        @(negedge clk); #1;
        req_valid  = 1'b1;
        req_erase  = erase;
        req_addr   = addr[FADDR_W-1:0];
        req_len    = len[LEN_W-1:0];
        req_src    = src[SRC_W-1:0];
        poll_limit = lim[POLL_W-1:0];
        active = 1;
        if (exp_q.size() == 0) fin_pending = 1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Cycle-by-cycle comparison and behavioural command engine.
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == active, "R8", "busy level", busy, active);
            if (fin_pending) begin
                check(done == 1'b1, fin_tag, "done pulse", done, 1);
                check(err == exp_err, fin_tag, "err flag", err, exp_err);
                check(exp_q.size() == 0, fin_tag, "commands left", exp_q.size(), 0);
                fin_pending = 0;
                active = 0;
            end else if (done) begin
                check(0, "R8", "unexpected done", done, 0);
            end
            cmd_done = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
            end else if (resp_cnt == 0) begin
                cmd_done  = 1'b1;
                cmd_rdata = resp_data;
                resp_cnt  = -1;
                if (resp_last) fin_pending = 1;
            end
            if (cmd_start) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected command", cmd_opcode, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cmd_opcode == e.op, t, "opcode", cmd_opcode, e.op);
                    check(cmd_addr == e.addr, t, "address", cmd_addr, e.addr);
                    check(cmd_mask == e.mask, "R10", "mask", cmd_mask, e.mask);
                    check(cmd_len == e.len, t, "length", cmd_len, e.len);
                    if (e.op == OP_PROG)
                        check(cmd_mem == e.mem, t, "source address", cmd_mem, e.mem);
                    resp_cnt  = 1 + (delay_seed % 3);
                    delay_seed++;
                    resp_data = e.rdata;
                    resp_last = (exp_q.size() == 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        check(busy == 1'b0, "R8", "reset busy", busy, 0);
        check(done == 1'b0, "R8", "reset done", done, 0);
        check(cmd_start == 1'b0, "R10", "reset cmd_start", cmd_start, 0);

        // R2 R3: unaligned start, first piece stops at page end
        plan_program(32'h0000F0, 40, 32'h001000, 2, 5);
        start_op(0, 32'h0000F0, 40, 32'h001000, 5);
        wait_idle();

        // R3: aligned start with short tail piece
        plan_program(32'h000200, 600, 32'h002000, 0, 4);
        start_op(0, 32'h000200, 600, 32'h002000, 4);
        wait_idle();

        // R2: one byte before a page boundary
        plan_program(32'h0012FF, 1, 32'h003000, 1, 4);
        start_op(0, 32'h0012FF, 1, 32'h003000, 4);
        wait_idle();

        // R2: length ends inside the first page
        plan_program(32'h000010, 10, 32'h004000, 0, 4);
        start_op(0, 32'h000010, 10, 32'h004000, 4);
        wait_idle();

        // R6: zero-length program fails without commands
        plan_program(32'h000050, 0, 32'h005000, 0, 4);
        start_op(0, 32'h000050, 0, 32'h005000, 4);
        wait_idle();

        // R4: two whole sectors
        plan_erase(32'h001000, 8192, 1, 4);
        start_op(1, 32'h001000, 8192, 0, 4);
        wait_idle();

        // R4: one byte past a sector multiple needs a second step
        plan_erase(32'h003010, 4097, 2, 4);
        start_op(1, 32'h003010, 4097, 0, 4);
        wait_idle();

        // R4: zero-length erase succeeds with no commands
        plan_erase(32'h005000, 0, 1, 4);
        start_op(1, 32'h005000, 0, 0, 4);
        wait_idle();

        // R7: one busy read beyond the limit aborts
        plan_program(32'h000100, 300, 32'h006000, 4, 2);
        start_op(0, 32'h000100, 300, 32'h006000, 2);
        wait_idle();

        // R7: exactly the limit of busy reads still passes
        plan_program(32'h000100, 20, 32'h006100, 3, 3);
        start_op(0, 32'h000100, 20, 32'h006100, 3);
        wait_idle();

        // R7: limit of zero aborts an erase on the first busy read
        plan_erase(32'h008000, 4096, 1, 0);
        start_op(1, 32'h008000, 4096, 0, 0);
        wait_idle();

        // R9: a request during a running operation is ignored
        plan_program(32'h000300, 100, 32'h007000, 3, 8);
        start_op(0, 32'h000300, 100, 32'h007000, 8);
        repeat (4) @(negedge clk);
        #1;
        req_valid = 1'b1; req_erase = 1'b1; req_addr = 24'h00A000;
        req_len = 20'd4096; req_src = '0; poll_limit = '0;
        @(negedge clk); #1;
        req_valid = 1'b0;
        wait_idle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule